// File: doc/BRIEF.md
# Store Write Buffer with Split Data and Address Queues

The block is a posted-write buffer between a core-side store port and a slower bus write master. The core offers one word per cycle with a word address. The buffer accepts each word at once as long as it has room. Words go into a data queue. Addresses are grouped in a separate, much shorter address queue, where each entry describes a run of consecutive words: a start address and a word count. A store whose address follows on from the newest entry joins that entry. Any other store opens a new entry. Entries leave in arrival order, and each one goes out as one incrementing burst on a valid/ready bus port.

The two queues have separate limits. The core can be stalled by a full data queue, or by a full address queue when its store would need a new entry. A flag input forces a new entry, so that a line evicted from a data cache arrives as one 4- or 8-word entry. A drain input stops further stores until everything has left the buffer, then pulses a done output. The buffer also reports full and empty status.

Top module: `wbuf_top`

## Requirements
- R1: After reset the buffer is empty: `st_ready`=1, `wb_empty`=1, `wb_full`=0, `bus_valid`=0, `drain_done`=0.
- R2: With the bus stalled, 16 words (DQ_DEPTH) are accepted. While the data queue holds 16 words, `st_ready` is 0 and `wb_full` is 1.
- R3: While all 4 (AQ_DEPTH) address entries are held, a store that needs a new entry is refused (`st_ready`=0, `wb_full`=1), even when the data queue has room.
- R4: A store is accepted in the cycle it is offered whenever room remains. A store is sequential when its word address equals the newest entry's start address plus that entry's count. A sequential store joins the newest entry if that entry is not being issued, and it is accepted even when all address entries are in use.
- R5: An entry holds 1 to 8 (MAX_RUN) words, and a word beyond 8 opens a new entry. While the only entry keeps growing from sequential stores, its issue waits until the growth stops.
- R6: The bus beats carry exactly the accepted (address, data) pairs in acceptance order. Nothing is lost, duplicated or reordered, and a refused store never appears.
- R7: Each entry leaves as one burst. `bus_len` equals the entry's word count for the whole burst, the address rises by one per beat, and `bus_last` marks the final beat. While `bus_ready` is 0, the beat's outputs hold.
- R8: `st_new`=1 opens a new entry even for a sequential address, so that a 4- or 8-word evicted line becomes a single burst of exactly that length.
- R9: `drain_req` refuses stores from the cycle it is raised. `drain_done` is a one-cycle pulse in the first cycle after the request in which both queues are empty, which is the next cycle when the buffer is already empty. Stores are accepted again the cycle after.
- R10: `wb_empty` is 1 exactly when no word is held, and `bus_valid` is 0 whenever `wb_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data |
| st_new | input | 1 | Force a new address entry |
| drain_req | input | 1 | Request to empty the buffer |
| drain_done | output | 1 | Pulse: buffer emptied after request |
| bus_valid | output | 1 | Bus beat valid |
| bus_ready | input | 1 | Bus takes the beat |
| bus_addr | output | ADDR_W | Word address of the beat |
| bus_data | output | DATA_W | Beat data |
| bus_len | output | LEN_W | Word count of the current burst |
| bus_last | output | 1 | Final beat of the burst |
| wb_empty | output | 1 | Nothing held |
| wb_full | output | 1 | Data queue or address queue full |

## Verification
The hardest state to reach is an address queue that is full while the data queue still has room, with a sequential store then arriving for a tail entry that is not the one being issued. The two queues normally fill together, so reaching this state needs a stalled bus and four non-sequential single-word stores. The bench holds `bus_ready` low and issues exactly that pattern. It then shows that a new-entry store is refused and that a store joining the tail is still taken. Seeded random traffic with a mostly-sequential address stream, random `st_new`, random bus back-pressure and occasional drain requests covers burst splitting and ordering against a queue-based scoreboard.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

   typedef enum logic {
      DR_IDLE  = 1'b0,
      DR_BURST = 1'b1
   } drain_state_e;

   // bits needed to hold a count from 0 to n
   function automatic int unsigned cnt_w(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/wbuf_dataq.sv
module wbuf_dataq #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW    = wbuf_pkg::cnt_w(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [CW-1:0]     count
);
   localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wp, rp, wp_nxt, rp_nxt;

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign wp_nxt = wp + 1'b1;
         assign rp_nxt = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nxt = (wp == LAST) ? '0 : wp + 1'b1;
         assign rp_nxt = (rp == LAST) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp_nxt;
         if (pop)  rp <= rp_nxt;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign rdata = mem[rp];

   AST_DQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < FULL_C || pop)); // R2
   AST_DQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0); // R6

endmodule

// File: rtl/wbuf_addrq.sv
module wbuf_addrq #(
   parameter int unsigned ADDR_W  = 30,
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned MAX_RUN = 8,
   localparam int unsigned PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW     = wbuf_pkg::cnt_w(DEPTH),
   localparam int unsigned LW     = wbuf_pkg::cnt_w(MAX_RUN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              st_new,
   input  logic              head_lock,
   input  logic              pop,
   output logic [ADDR_W-1:0] head_base,
   output logic [LW-1:0]     head_len,
   output logic [CW-1:0]     count,
   output logic              append_ok,
   output logic              tail_growing
);
   localparam logic [PW-1:0] LAST    = PW'(DEPTH - 1);
   localparam logic [LW-1:0] RUN_MAX = LW'(MAX_RUN);
   localparam logic [CW-1:0] ONE_C   = CW'(1);
   localparam logic [CW-1:0] FULL_C  = CW'(DEPTH);

   logic [ADDR_W-1:0] base [DEPTH];
   logic [LW-1:0]     len  [DEPTH];
   logic [PW-1:0]     wp, rp, wp_nxt, rp_nxt, tp;
   logic              seq_hit, do_new, do_app;

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign wp_nxt = wp + 1'b1;
         assign rp_nxt = rp + 1'b1;
         assign tp     = wp - 1'b1;
      end else begin : g_wrap
         assign wp_nxt = (wp == LAST) ? '0 : wp + 1'b1;
         assign rp_nxt = (rp == LAST) ? '0 : rp + 1'b1;
         assign tp     = (wp == '0) ? LAST : wp - 1'b1;
      end
   endgenerate

   // a store continues the newest run when it lands right after it
   assign seq_hit      = (count != '0) && !st_new && (len[tp] != RUN_MAX) &&
                         (st_addr == base[tp] + ADDR_W'(len[tp]));
   assign append_ok    = seq_hit && !((count == ONE_C) && head_lock);
   assign tail_growing = push && seq_hit && (count == ONE_C);
   assign do_app       = push && append_ok;
   assign do_new       = push && !append_ok;

   always_ff @(posedge clk) begin
      if (do_new) begin
         base[wp] <= st_addr;
         len[wp]  <= LW'(1);
      end
      if (do_app) len[tp] <= len[tp] + LW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_new) wp <= wp_nxt;
         if (pop)    rp <= rp_nxt;
         count <= count + CW'(do_new) - CW'(pop);
      end
   end

   assign head_base = base[rp];
   assign head_len  = len[rp];

   AST_AQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      do_new |-> (count < FULL_C || pop)); // R3
   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (count != '0) |-> (head_len != '0 && head_len <= RUN_MAX)); // R5

endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain
   import wbuf_pkg::*;
#(
   parameter int unsigned ADDR_W = 30,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              have_entry,
   input  logic              start_ok,
   input  logic [ADDR_W-1:0] head_base,
   input  logic [LW-1:0]     head_len,
   input  logic [DATA_W-1:0] rdata,
   input  logic              bus_ready,
   output logic              bus_valid,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic [LW-1:0]     bus_len,
   output logic              bus_last,
   output logic              active,
   output logic              beat_take,
   output logic              burst_end
);
   drain_state_e state;
   logic [LW-1:0] beat;

   assign active    = (state == DR_BURST);
   assign bus_valid = active;
   assign bus_addr  = head_base + ADDR_W'(beat);
   assign bus_data  = rdata;
   assign bus_len   = head_len;
   assign bus_last  = active && (beat == head_len - LW'(1));
   assign beat_take = active && bus_ready;
   assign burst_end = beat_take && bus_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= DR_IDLE;
         beat  <= '0;
      end else begin
         unique case (state)
            DR_IDLE: if (have_entry && start_ok) begin
               state <= DR_BURST;
               beat  <= '0;
            end
            DR_BURST: if (beat_take) begin
               if (bus_last) state <= DR_IDLE;
               else          beat  <= beat + LW'(1);
            end
            default: state <= DR_IDLE;
         endcase
      end
   end

   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                     $stable(bus_data) && $stable(bus_len))); // R7
   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_ready && !bus_last) |=>
         (bus_valid && bus_addr == $past(bus_addr) + ADDR_W'(1))); // R7

endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
   parameter int unsigned ADDR_W   = 30,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DQ_DEPTH = 16,
   parameter int unsigned AQ_DEPTH = 4,
   parameter int unsigned MAX_RUN  = 8,
   localparam int unsigned LEN_W   = wbuf_pkg::cnt_w(MAX_RUN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   output logic              st_ready,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic              st_new,
   input  logic              drain_req,
   output logic              drain_done,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic [LEN_W-1:0]  bus_len,
   output logic              bus_last,
   output logic              wb_empty,
   output logic              wb_full
);
   localparam int unsigned DCW = wbuf_pkg::cnt_w(DQ_DEPTH);
   localparam int unsigned ACW = wbuf_pkg::cnt_w(AQ_DEPTH);
   localparam logic [DCW-1:0] DQ_FULL = DCW'(DQ_DEPTH);
   localparam logic [ACW-1:0] AQ_FULL = ACW'(AQ_DEPTH);

   initial begin
      AST_CFG_RUN: assert (MAX_RUN >= 1 && DQ_DEPTH >= MAX_RUN)
         else $error("data queue must hold at least one full run"); // R5
      AST_CFG_ADDR: assert (AQ_DEPTH >= 2)
         else $error("address queue needs two or more entries"); // R3
   end

   logic [DCW-1:0]    dq_count;
   logic [ACW-1:0]    aq_count;
   logic [DATA_W-1:0] dq_rdata;
   logic [ADDR_W-1:0] head_base;
   logic [LEN_W-1:0]  head_len;
   logic              append_ok, tail_growing;
   logic              active, beat_take, burst_end;
   logic              drain_pend, blocked, dq_room, aq_room, st_fire;

   assign blocked  = drain_req || drain_pend;
   assign dq_room  = dq_count < DQ_FULL;
   assign aq_room  = aq_count < AQ_FULL;
   assign st_ready = !blocked && dq_room && (append_ok || aq_room);
   assign st_fire  = st_valid && st_ready;

   assign wb_empty   = (aq_count == '0) && (dq_count == '0);
   assign wb_full    = !dq_room || !aq_room;
   assign drain_done = drain_pend && wb_empty;

   always_ff @(posedge clk) begin
      if (!rst_n)          drain_pend <= 1'b0;
      else if (drain_done) drain_pend <= 1'b0;
      else if (drain_req)  drain_pend <= 1'b1;
   end

   wbuf_dataq #(.DATA_W(DATA_W), .DEPTH(DQ_DEPTH)) u_dataq (
      .clk(clk), .rst_n(rst_n), .push(st_fire), .wdata(st_data),
      .pop(beat_take), .rdata(dq_rdata), .count(dq_count)
   );

   wbuf_addrq #(.ADDR_W(ADDR_W), .DEPTH(AQ_DEPTH), .MAX_RUN(MAX_RUN)) u_addrq (
      .clk(clk), .rst_n(rst_n), .push(st_fire), .st_addr(st_addr),
      .st_new(st_new), .head_lock(active), .pop(burst_end),
      .head_base(head_base), .head_len(head_len), .count(aq_count),
      .append_ok(append_ok), .tail_growing(tail_growing)
   );

   wbuf_drain #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LW(LEN_W)) u_drain (
      .clk(clk), .rst_n(rst_n), .have_entry(aq_count != '0),
      .start_ok(!tail_growing), .head_base(head_base), .head_len(head_len),
      .rdata(dq_rdata), .bus_ready(bus_ready), .bus_valid(bus_valid),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_len(bus_len),
      .bus_last(bus_last), .active(active), .beat_take(beat_take),
      .burst_end(burst_end)
   );

   AST_DATA_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> dq_count != '0); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done |=> !drain_done); // R9
   AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_empty |-> !bus_valid); // R10

endmodule

// File: tb/wbuf_top_tb.sv
module wbuf_top_tb;
   localparam int AW = 30;
   localparam int DW = 32;
   localparam int MAXR = 8;
   localparam int LW = $clog2(MAXR + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic st_valid = 1'b0, st_new = 1'b0, drain_req = 1'b0, bus_ready = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic st_ready, drain_done, bus_valid, bus_last, wb_empty, wb_full;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data;
   logic [LW-1:0] bus_len;

   always #10 clk = ~clk;

   wbuf_top u_dut (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
      .st_addr(st_addr), .st_data(st_data), .st_new(st_new),
      .drain_req(drain_req), .drain_done(drain_done), .bus_valid(bus_valid),
      .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_len(bus_len), .bus_last(bus_last), .wb_empty(wb_empty),
      .wb_full(wb_full)
   );

   int n_checks = 0, n_err = 0, done_cnt = 0;
   bit finished = 1'b0;
   logic [AW+DW-1:0] exp_q[$];
   int obs_len[$];
   int beats_left = 0;
   int cur_len = 0;
   logic [AW-1:0] prev_addr = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: sample at the falling edge, handshakes complete at the next rise
   always @(negedge clk) begin
      if (rst_n) begin
         if (st_valid && st_ready) exp_q.push_back({st_addr, st_data});
         if (drain_done) done_cnt++;
         if (bus_valid && bus_ready) begin
            if (beats_left == 0) begin
               obs_len.push_back(int'(bus_len));
               chk(bus_len >= 1 && bus_len <= MAXR, "R5", "burst length",
                   bus_len, MAXR);
               beats_left = int'(bus_len);
               cur_len = int'(bus_len);
            end else begin
               chk(bus_addr == prev_addr + 1, "R7", "burst address step",
                   bus_addr, prev_addr + 1);
               chk(int'(bus_len) == cur_len, "R7", "length held", bus_len, cur_len);
            end
            chk(bus_last == (beats_left == 1), "R7", "last flag", bus_last,
                beats_left == 1);
            if (exp_q.size() == 0)
               chk(1'b0, "R6", "unexpected beat", bus_addr, 0);
            else begin
               chk({bus_addr, bus_data} == exp_q[0], "R6", "beat content",
                   {bus_addr, bus_data}, exp_q[0]);
               void'(exp_q.pop_front());
            end
            prev_addr = bus_addr;
            beats_left--;
         end
      end
   end

   task automatic put(input logic [AW-1:0] a, input bit nw, output int waits);
      st_valid = 1'b1; st_addr = a; st_data = $urandom; st_new = nw;
      waits = 0;
      while (1) begin
         @(negedge clk);
         if (st_ready) break;
         waits++;
      end
      @(posedge clk); #2;
      st_valid = 1'b0; st_new = 1'b0;
   endtask

   task automatic wait_empty();
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (wb_empty && !bus_valid) break;
      end
      @(posedge clk); #2;
   endtask

   task automatic check_lens(input string req, input int n, input int l0,
                             input int l1, input int l2, input int l3);
      int e[4];
      e[0] = l0; e[1] = l1; e[2] = l2; e[3] = l3;
      chk(obs_len.size() == n, req, "burst count", obs_len.size(), n);
      for (int i = 0; i < n && i < obs_len.size(); i++)
         chk(obs_len[i] == e[i], req, "burst length", obs_len[i], e[i]);
      chk(exp_q.size() == 0, "R6", "words left over", exp_q.size(), 0);
      chk(wb_empty == 1'b1, "R10", "empty after drain", wb_empty, 1);
      obs_len.delete();
   endtask

   initial begin
      repeat (1500000) @(posedge clk);
      if (!finished) begin
         n_err++; n_checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      int w;
      logic [AW-1:0] last_a;
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(st_ready == 1, "R1", "reset st_ready", st_ready, 1);
      chk(wb_empty == 1, "R1", "reset empty", wb_empty, 1);
      chk(wb_full == 0, "R1", "reset full", wb_full, 0);
      chk(bus_valid == 0, "R1", "reset bus_valid", bus_valid, 0);
      chk(drain_done == 0, "R1", "reset done", drain_done, 0);
      @(posedge clk); #2; rst_n = 1'b1;
      @(posedge clk); #2;

      // data capacity, no stall while room, eviction-style runs
      bus_ready = 1'b0;
      for (int i = 0; i < 8; i++) begin
         put(30'h100 + 30'(i), i == 0, w);
         chk(w == 0, "R4", "accepted without wait", w, 0);
      end
      chk(wb_empty == 0, "R10", "not empty while holding", wb_empty, 0);
      for (int i = 0; i < 8; i++) begin
         put(30'h200 + 30'(i), i == 0, w);
         chk(w == 0, "R4", "accepted without wait", w, 0);
      end
      st_valid = 1'b1; st_addr = 30'h208; st_new = 1'b0;
      @(negedge clk);
      chk(st_ready == 0, "R2", "stall on full data queue", st_ready, 0);
      chk(wb_full == 1, "R2", "full flag", wb_full, 1);
      @(posedge clk); #2; st_valid = 1'b0;
      bus_ready = 1'b1;
      wait_empty();
      check_lens("R8", 2, 8, 8, 0, 0);

      // address capacity with data room, then joining the tail
      bus_ready = 1'b0;
      put(30'h10, 0, w); put(30'h20, 0, w); put(30'h30, 0, w); put(30'h40, 0, w);
      st_valid = 1'b1; st_addr = 30'h50; st_data = $urandom;
      @(negedge clk);
      chk(st_ready == 0, "R3", "new entry refused", st_ready, 0);
      chk(wb_full == 1, "R3", "full flag", wb_full, 1);
      @(posedge clk); #2;
      put(30'h41, 0, w);
      chk(w == 0, "R4", "sequential joins tail", w, 0);
      bus_ready = 1'b1;
      wait_empty();
      check_lens("R4", 4, 1, 1, 1, 2);

      // run length cap
      bus_ready = 1'b0;
      for (int i = 0; i < 10; i++) put(30'h400 + 30'(i), 0, w);
      bus_ready = 1'b1;
      wait_empty();
      check_lens("R5", 2, 8, 2, 0, 0);

      // forced new entry for a sequential address
      bus_ready = 1'b0;
      put(30'h500, 0, w);
      for (int i = 1; i < 5; i++) put(30'h500 + 30'(i), i == 1, w);
      bus_ready = 1'b1;
      wait_empty();
      check_lens("R8", 2, 1, 4, 0, 0);

      // drain with contents
      bus_ready = 1'b0;
      put(30'h600, 0, w); put(30'h601, 0, w); put(30'h700, 0, w);
      done_cnt = 0;
      drain_req = 1'b1; st_valid = 1'b1; st_addr = 30'h701; st_data = $urandom;
      @(negedge clk);
      chk(st_ready == 0, "R9", "blocked in request cycle", st_ready, 0);
      @(posedge clk); #2; drain_req = 1'b0; bus_ready = 1'b1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (drain_done) break;
         chk(st_ready == 0, "R9", "blocked while draining", st_ready, 0);
      end
      chk(drain_done == 1, "R9", "done seen", drain_done, 1);
      chk(exp_q.size() == 0 && wb_empty, "R9", "empty at done", exp_q.size(), 0);
      @(negedge clk);
      chk(drain_done == 0, "R9", "done is one pulse", drain_done, 0);
      chk(st_ready == 1, "R9", "stores resume", st_ready, 1);
      @(posedge clk); #2; st_valid = 1'b0;
      wait_empty();
      chk(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
      obs_len.delete();

      // drain when already empty
      drain_req = 1'b1;
      @(negedge clk);
      chk(drain_done == 0, "R9", "no done in request cycle", drain_done, 0);
      @(posedge clk); #2; drain_req = 1'b0;
      @(negedge clk);
      chk(drain_done == 1, "R9", "done next cycle when empty", drain_done, 1);
      @(posedge clk); #2;

      // seeded random traffic
      last_a = 30'h1000;
      for (int i = 0; i < 1500; i++) begin
         st_valid = ($urandom % 5) != 0;
         st_addr = (($urandom % 10) < 7) ? last_a + 30'd1 : 30'($urandom % 4096);
         st_data = $urandom;
         st_new = ($urandom % 10) == 0;
         bus_ready = ($urandom % 3) != 0;
         drain_req = ($urandom % 100) == 0;
         @(negedge clk);
         if (st_valid && st_ready) last_a = st_addr;
         @(posedge clk); #2;
      end
      st_valid = 1'b0; drain_req = 1'b0; bus_ready = 1'b1;
      wait_empty();
      repeat (2) @(posedge clk);
      chk(exp_q.size() == 0, "R6", "random traffic fully drained", exp_q.size(), 0);
      chk(wb_empty == 1, "R10", "empty after random", wb_empty, 1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule